// File: doc/BRIEF.md
# Wide AES-Style Permutation Engine

This block computes one of two fixed 512-bit permutations, called P and Q, of an AES-style hash function. The 512-bit state is held as an 8 by 8 matrix of bytes. Every round works through four steps in a fixed order: a round constant is added, every byte goes through the AES substitution box, each row is rotated, and every column is multiplied by a circulant matrix over GF(2^8). The engine performs one full round per clock cycle and needs ten rounds for one permutation.

A load is a valid/ready transfer. The source drives `in_valid` together with the 512-bit state and the P/Q choice. The engine takes the transfer on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for as long as the engine is busy. A source that offers a load during that time simply waits: the engine leaves the offered word untouched until `in_ready` rises again. No back-pressure is applied on the result. It is marked by a one-cycle `done` pulse and remains on `out_data` until the next load is taken. A new load may be taken in the same cycle in which `done` is high.

Top module: `grp_perm_engine`

## Requirements
- R1: A load is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `busy` is low. After the load edge `busy` is high.
- R2: `busy` stays high for exactly 10 clock cycles after the load edge. `done` is high for exactly one cycle, namely the cycle after the tenth round edge, and `busy` is low in that cycle.
- R3: The P/Q choice and the state are sampled only on the load edge. Changes on `in_data`, `in_sel_q` and `in_valid` while `busy` is high have no effect on the result.
- R4: Byte k of a 512-bit word occupies bits [511-8k -: 8], so byte 0 is the most significant byte. It maps to row k mod 8 and column k div 8. The same mapping applies on input and output.
- R5: Each round applies the constant addition, then the substitution, then the row rotation, then the column mixing. The substitution is the AES S-box: the inverse in GF(2^8) modulo 0x11B followed by the affine map with constant 0x63.
- R6: P (`in_sel_q` = 0) in round i (0..9) XORs row 0, column j with the byte {j, i}, where j is the high nibble and i the low nibble. All other rows are left unchanged.
- R7: Q (`in_sel_q` = 1) in round i XORs every byte with 0xFF. It also XORs row 7, column j with {j, i}.
- R8: Row r is rotated left by s[r] columns, so new column c takes old column (c + s[r]) mod 8. For P, s = r. For Q, s = 1,3,5,7,0,2,4,6 for rows 0..7.
- R9: Column mixing sets output row i to the XOR over j of coef[(j - i) mod 8] times input row j, using GF(2^8) with 0x11B. coef[0..7] = 02,02,03,04,05,03,05,07.
- R10: While `busy` is low and no load is taken, `out_data` does not change.
- R11: An asynchronous active-low `rst_n` clears `busy`, `done` and the round counter at once. A load after reset runs the full 10 rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A state word is offered for loading |
| in_ready | output | 1 | Engine can take a load (not busy) |
| in_sel_q | input | 1 | 0 selects P, 1 selects Q; sampled on the load edge |
| in_data | input | 512 | State to permute, column-ordered bytes |
| busy | output | 1 | Rounds are in progress |
| done | output | 1 | One-cycle pulse: result is ready |
| out_data | output | 512 | Permuted state, held until the next load |

## Verification
The collision of interest is the `done` pulse of one permutation arriving in the same cycle as the load of the next. The bench provokes it by offering a new word in the very cycle `done` is seen, over a chain of three mixed P and Q jobs. It then judges that the first result is correct in that cycle. It also checks that the next cycle shows `busy` with `done` low, and that the second job still takes exactly ten rounds and gives its own correct result. Noise on the load port while busy, and a reset in the middle of a run, are checked against the same bench model.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int NROW  = 8;
  localparam int NCOL  = 8;
  localparam int NBYTE = NROW * NCOL;

  // byte k = column (k / NROW), row (k % NROW); element 0 is the MSB
  typedef logic [0:NBYTE-1][7:0] st_t;
  typedef logic [0:NROW-1][7:0]  col_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xt(p);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, base);
      base = gmul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] a);
    logic [7:0] v;
    v = ginv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // left rotation amount of row r
  function automatic int shamt(input bit q, input int r);
    if (!q) return r;
    case (r)
      0: return 1;
      1: return 3;
      2: return 5;
      3: return 7;
      4: return 0;
      5: return 2;
      6: return 4;
      default: return 6;
    endcase
  endfunction

  // circulant mixing coefficient for output row i, input row j
  function automatic logic [7:0] mb_coef(input int i, input int j);
    case ((j - i + NROW) % NROW)
      0, 1:    return 8'h02;
      2, 5:    return 8'h03;
      3:       return 8'h04;
      4, 6:    return 8'h05;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/grp_sbox.sv
module grp_sbox (
  input  logic [7:0] a,
  output logic [7:0] y
);
  import grp_pkg::*;
  assign y = sbox_f(a);
endmodule

// File: rtl/grp_mix_column.sv
module grp_mix_column (
  input  grp_pkg::col_t col_in,
  output grp_pkg::col_t col_out
);
  import grp_pkg::*;

  always_comb begin
    logic [7:0] acc;
    for (int i = 0; i < NROW; i++) begin
      acc = 8'h00;
      for (int j = 0; j < NROW; j++) begin
        acc = acc ^ gmul(col_in[j], mb_coef(i, j));
      end
      col_out[i] = acc;
    end
  end
endmodule

// File: rtl/grp_round.sv
module grp_round (
  input  grp_pkg::st_t st_in,
  input  logic         is_q,
  input  logic [3:0]   rnd,
  output grp_pkg::st_t st_out
);
  import grp_pkg::*;

  st_t ac;
  st_t sb;
  st_t sh;

  // constant addition
  always_comb begin
    logic [7:0] b;
    for (int c = 0; c < NCOL; c++) begin
      for (int r = 0; r < NROW; r++) begin
        b = st_in[c*NROW + r];
        if (is_q) begin
          b = b ^ 8'hff;
          if (r == NROW - 1) b = b ^ {4'(c), rnd};
        end else if (r == 0) begin
          b = b ^ {4'(c), rnd};
        end
        ac[c*NROW + r] = b;
      end
    end
  end

  // substitution
  for (genvar k = 0; k < NBYTE; k++) begin : g_sub
    grp_sbox u_sbox (.a(ac[k]), .y(sb[k]));
  end

  // row rotation, both schedules wired and selected
  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam int SP = shamt(1'b0, r);
    localparam int SQ = shamt(1'b1, r);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      assign sh[c*NROW + r] = is_q ? sb[((c + SQ) % NCOL)*NROW + r]
                                   : sb[((c + SP) % NCOL)*NROW + r];
    end
  end

  // column mixing
  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    col_t cin;
    col_t cout;
    for (genvar r = 0; r < NROW; r++) begin : g_tap
      assign cin[r] = sh[c*NROW + r];
      assign st_out[c*NROW + r] = cout[r];
    end
    grp_mix_column u_mix (.col_in(cin), .col_out(cout));
  end
endmodule

// File: rtl/grp_perm_engine.sv
module grp_perm_engine #(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_sel_q,
  input  logic [511:0] in_data,
  output logic         busy,
  output logic         done,
  output logic [511:0] out_data
);
  import grp_pkg::*;

  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  st_t          state_q;
  st_t          state_nxt;
  logic         sel_q;
  logic         busy_q;
  logic         done_q;
  logic [RW-1:0] rnd_q;

  grp_round u_round (
    .st_in (state_q),
    .is_q  (sel_q),
    .rnd   (4'(rnd_q)),
    .st_out(state_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      sel_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rnd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        state_q <= state_nxt;
        if (rnd_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rnd_q  <= '0;
        end else begin
          rnd_q <= rnd_q + 1'b1;
        end
      end else if (in_valid) begin
        state_q <= in_data;
        sel_q   <= in_sel_q;
        busy_q  <= 1'b1;
        rnd_q   <= '0;
      end
    end
  end

  assign in_ready = !busy_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign out_data = state_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy_q && rnd_q == '0)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_LAST_ROUND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rnd_q == LAST) |=> (done_q && !busy_q)); // R2
  AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q <= LAST); // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q)); // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !in_valid) |=> $stable(state_q)); // R10
endmodule

// File: tb/test_grp_perm_engine.sv
module test_grp_perm_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sel_q = 1'b0;
  logic [511:0] in_data = '0;
  logic         busy;
  logic         done;
  logic [511:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;
  logic [7:0]   sb_tab [256];
  logic [63:0]  seed = 64'h9e3779b97f4a7c15;
  logic [511:0] last_exp = '0;
  int sig_p [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  int sig_q [8] = '{1, 3, 5, 7, 0, 2, 4, 6};
  logic [7:0] coef [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_perm_engine i_grp_perm_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel_q(in_sel_q), .in_data(in_data), .busy(busy), .done(done),
    .out_data(out_data)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mul2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x = a;
    logic [7:0] y = b;
    logic [7:0] s = 8'h00;
    while (y != 0) begin
      if (y[0]) s ^= x;
      x = mul2(x);
      y = y >> 1;
    end
    return s;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v = 8'h00;
      logic [7:0] o;
      for (int y = 1; y < 256; y++)
        if (bmul(8'(x), 8'(y)) == 8'h01) v = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ 8'h63 >> i;
      sb_tab[x] = o;
    end
  endtask

  task automatic ref_perm(input bit q, input logic [511:0] din, output logic [511:0] dout);
    logic [7:0] a [8][8];
    logic [7:0] t [8][8];
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        a[r][c] = din[511 - 8*(8*c + r) -: 8];
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < 8; c++) begin
        if (q) begin
          for (int r = 0; r < 8; r++) a[r][c] ^= 8'hff;
          a[7][c] ^= {4'(c), 4'(i)};
        end else begin
          a[0][c] ^= {4'(c), 4'(i)};
        end
      end
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) a[r][c] = sb_tab[a[r][c]];
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          t[r][c] = a[r][(c + (q ? sig_q[r] : sig_p[r])) % 8];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) begin
          logic [7:0] s = 8'h00;
          for (int j = 0; j < 8; j++) s ^= bmul(coef[(j - r + 8) % 8], t[j][c]);
          a[r][c] = s;
        end
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        dout[511 - 8*(8*c + r) -: 8] = a[r][c];
  endtask

  task automatic next_rand(output logic [511:0] v);
    for (int w = 0; w < 8; w++) begin
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      v[w*64 +: 64] = seed;
    end
  endtask

  // called at a falling edge; returns at the falling edge where done is expected
  task automatic run_op(input bit q, input logic [511:0] d, input bit noise);
    logic [511:0] exp;
    bit busy_ok = 1'b1;
    string tags;
    ref_perm(q, d, exp);
    tags = q ? "R4 R5 R7 R8 R9" : "R4 R5 R6 R8 R9";
    in_valid = 1'b1;
    in_sel_q = q;
    in_data  = d;
    @(negedge clk);
    check(busy && !in_ready && !done, "R1 load taken",
          {509'd0, busy, in_ready, done}, {509'd0, 3'b100});
    for (int k = 1; k <= 10; k++) begin
      if (noise) begin
        in_valid = 1'b1;
        in_sel_q = ~q;
        in_data  = ~d;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (k < 10 && !(busy && !done && !in_ready)) busy_ok = 1'b0;
    end
    in_valid = 1'b0;
    check(busy_ok, "R2 busy for ten cycles", {511'd0, busy_ok}, 512'd1);
    check(done && !busy, "R2 done pulse after tenth round",
          {510'd0, done, busy}, {510'd0, 2'b10});
    check(out_data === exp, noise ? "R3 load port noise while busy" : tags, out_data, exp);
    last_exp = exp;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_data  = ~in_data;
      in_sel_q = ~in_sel_q;
      @(negedge clk);
      check(!done && !busy && in_ready, "R2 done single cycle",
            {510'd0, done, busy}, 512'd0);
      check(out_data === last_exp, "R10 result held", out_data, last_exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [511:0] v;
    build_sbox();
    check(sb_tab[0] == 8'h63 && sb_tab[1] == 8'h7c && sb_tab[8'h53] == 8'hed,
          "R5 bench substitution model", {488'd0, sb_tab[0], sb_tab[1], sb_tab[8'h53]},
          {488'd0, 24'h637ced});
    repeat (2) @(negedge clk);
    check(!busy && !done && in_ready && out_data == '0, "R11 reset state",
          {509'd0, busy, done, in_ready}, 512'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // pattern sweep over both permutations
    for (int idx = 0; idx < 16; idx++) begin
      case (idx)
        0: v = '0;
        1: v = '1;
        2: for (int k = 0; k < 64; k++) v[511 - 8*k -: 8] = 8'(k);
        3, 4, 5, 6, 7: begin
          int pos [5] = '{0, 7, 8, 63, 36};
          v = '0;
          v[511 - 8*pos[idx-3] -: 8] = 8'h01;
        end
        default: next_rand(v);
      endcase
      run_op(idx[0], v, 1'b0);
      idle(2);
    end

    // load port activity while busy: ignored, sampled values kept
    next_rand(v);
    run_op(1'b0, v, 1'b1);
    idle(3);
    next_rand(v);
    run_op(1'b1, v, 1'b1);
    idle(1);

    // collision: next load taken in the done cycle
    next_rand(v);
    run_op(1'b1, v, 1'b0);
    next_rand(v);
    run_op(1'b0, v, 1'b0);
    next_rand(v);
    run_op(1'b1, v, 1'b0);
    idle(2);

    // reset in the middle of a run
    next_rand(v);
    in_valid = 1'b1;
    in_sel_q = 1'b0;
    in_data  = v;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(!busy && !done && in_ready, "R11 async reset mid-run",
          {509'd0, busy, done, in_ready}, 512'd1);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    next_rand(v);
    run_op(1'b0, v, 1'b0);
    idle(1);

    report();
    $finish;
  end
endmodule